// File: doc/BRIEF.md
# Legacy NMI Source Collector

This unit collects the two classic non-maskable interrupt causes of a PC-style platform, a bus parity or system error and an active-low I/O channel check, keeps their status visible to software and drives one NMI request line towards the processor. It sits on a simple byte-wide I/O bus and answers two port addresses. The control port at 61h holds the per-source disables, the status flags and a few unrelated system signals: speaker data, the counter-2 gate, the counter-2 output and a refresh toggle. Bit 7 of the port at 70h is a global NMI mask. The remaining index bits of a 70h write go out unchanged to the real-time-clock index bus.

A handler reads 61h to find the cause. It clears a latched parity or system error by writing its disable bit high and then low again. The channel-check flag follows the synchronized input level. All asynchronous inputs pass through two-flop synchronizers. The reset input is asserted asynchronously and released synchronously.

Top module: `nmi_legacy_unit`

## Requirements
- R1: Port 61h bit 7 becomes 1 when perr_n or serr_n is sampled low while bit 2 is 0. It stays 1 after the inputs return high, until it is cleared.
- R2: While port 61h bit 2 is 1, bit 7 reads 0 and new parity or system errors do not set it. Writing 1 and then 0 to bit 2 clears a latched bit 7.
- R3: Port 61h bit 6 reads 1 while iochk_n is low and bit 3 is 0. It reads 0 once iochk_n is high again.
- R4: While port 61h bit 3 is 1, bit 6 reads 0 whatever the level of iochk_n.
- R5: nmi is 1 exactly when (bit 7 or bit 6 of port 61h) is 1 and the global mask is 0.
- R6: A write to port 70h loads the global mask from data bit 7. The same write drives data bits 5..0 onto rtc_idx. A read of 70h returns {mask, last written bit 6, rtc_idx}.
- R7: Port 61h bits 3..0 read back as last written. Bit 1 drives spk_data and bit 0 drives ctr2_gate.
- R8: Port 61h bit 4 inverts on every rising edge of the synchronized rfsh_req input.
- R9: Port 61h bit 5 reads the synchronized level of ctr2_out.
- R10: After reset, port 61h reads 00h with all inputs idle (perr_n, serr_n and iochk_n high; rfsh_req and ctr2_out low), nmi is 0, rtc_idx is 0 and the global mask is 1.
- R11: Writes to any address other than 61h and 70h change no state. Reads from such an address return 00h.
- R12: An input change is reflected in port 61h and nmi no later than the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr (combinational) |
| perr_n | input | 1 | Bus parity error, active low, asynchronous |
| serr_n | input | 1 | Bus system error, active low, asynchronous |
| iochk_n | input | 1 | I/O channel check, active low, asynchronous |
| rfsh_req | input | 1 | Refresh event, one high pulse per refresh |
| ctr2_out | input | 1 | Interval counter 2 output |
| spk_data | output | 1 | Speaker data bit |
| ctr2_gate | output | 1 | Counter 2 gate, 1 lets the counter run |
| rtc_idx | output | 6 | RTC index from the last 70h write |
| nmi | output | 1 | NMI request to the processor |

## Verification
The bench checks that a parity error latches and survives its input going away. A design that tracked the level would lose the cause before the handler read it. It checks that the 1-then-0 pulse on the disable bit clears the flag and that a held disable blocks both setting and the NMI. A design that cleared only on a write of 0 would keep a stale NMI asserted. It checks that the global mask blocks nmi while leaving the status readable, that a 70h write with bit 6 set leaves the mask clear, and that a write to a neighbouring address leaves both ports unchanged. The refresh toggle is driven with two pulses, which catches a design that follows the level instead of inverting on each edge.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned IDX_W = 6;

  typedef struct packed {
    logic dis_chk;
    logic dis_par;
    logic spk;
    logic gate;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{dis_chk: 1'b0, dis_par: 1'b0, spk: 1'b0, gate: 1'b0};
endpackage

// File: rtl/nmi_sync_bank.sv
module nmi_sync_bank #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= din[i];
        sync_q <= meta_q;
      end
    end
    assign dout[i] = sync_q;
  end
endmodule

// File: rtl/nmi_status_core.sv
module nmi_status_core (
  input  logic clk,
  input  logic rst_n,
  input  logic par_evt,
  input  logic chk_lvl,
  input  logic rfsh_lvl,
  input  logic dis_par,
  input  logic dis_chk,
  output logic par_st,
  output logic chk_st,
  output logic rfsh_tgl
);
  logic par_d, chk_d, tgl_d, rfsh_prev_q, rfsh_rise;

  assign rfsh_rise = rfsh_lvl & ~rfsh_prev_q;

  always_comb begin
    par_d = dis_par ? 1'b0 : (par_st | par_evt);
    chk_d = dis_chk ? 1'b0 : chk_lvl;
    tgl_d = rfsh_rise ? ~rfsh_tgl : rfsh_tgl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_st      <= 1'b0;
      chk_st      <= 1'b0;
      rfsh_tgl    <= 1'b0;
      rfsh_prev_q <= 1'b0;
    end else begin
      par_st      <= par_d;
      chk_st      <= chk_d;
      rfsh_tgl    <= tgl_d;
      rfsh_prev_q <= rfsh_lvl;
    end
  end
endmodule

// File: rtl/nmi_host_regs.sv
module nmi_host_regs
  import nmi_pkg::*;
#(
  parameter logic [AW-1:0] CTRL_ADDR = 8'h61,
  parameter logic [AW-1:0] MASK_ADDR = 8'h70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    io_addr,
  input  logic             io_wr,
  input  logic [DW-1:0]    io_wdata,
  input  logic             par_st,
  input  logic             chk_st,
  input  logic             rfsh_tgl,
  input  logic             ctr2_s,
  output ctrl_t            ctrl_q,
  output logic             mask_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [DW-1:0]    io_rdata
);
  logic             ctrl_en, mask_en;
  ctrl_t            ctrl_d;
  logic             mask_d, spare_q, spare_d;
  logic [IDX_W-1:0] idx_d;

  assign ctrl_en = io_wr && (io_addr == CTRL_ADDR);
  assign mask_en = io_wr && (io_addr == MASK_ADDR);

  always_comb begin
    ctrl_d  = ctrl_q;
    mask_d  = mask_q;
    spare_d = spare_q;
    idx_d   = idx_q;
    if (ctrl_en) ctrl_d = ctrl_t'(io_wdata[3:0]);
    if (mask_en) begin
      mask_d  = io_wdata[7];
      spare_d = io_wdata[6];
      idx_d   = io_wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      mask_q  <= 1'b1;
      spare_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      mask_q  <= mask_d;
      spare_q <= spare_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_addr == CTRL_ADDR)
      io_rdata = {par_st, chk_st, ctr2_s, rfsh_tgl, ctrl_q};
    else if (io_addr == MASK_ADDR)
      io_rdata = {mask_q, spare_q, idx_q};
  end
endmodule

// File: rtl/nmi_legacy_unit.sv
module nmi_legacy_unit
  import nmi_pkg::*;
#(
  parameter logic [AW-1:0] CTRL_ADDR = 8'h61,
  parameter logic [AW-1:0] MASK_ADDR = 8'h70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    io_addr,
  input  logic             io_wr,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  input  logic             perr_n,
  input  logic             serr_n,
  input  logic             iochk_n,
  input  logic             rfsh_req,
  input  logic             ctr2_out,
  output logic             spk_data,
  output logic             ctr2_gate,
  output logic [IDX_W-1:0] rtc_idx,
  output logic             nmi
);
  localparam int unsigned NSYNC = 5;
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b11100;

  logic             rst_m_q, srst_n;
  logic [NSYNC-1:0] async_in, sync_out;
  logic             perr_s_n, serr_s_n, chk_s_n, rfsh_s, ctr2_s;
  logic             par_st, chk_st, rfsh_tgl, mask_q;
  ctrl_t            ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      srst_n  <= rst_m_q;
    end
  end

  assign async_in = {perr_n, serr_n, iochk_n, rfsh_req, ctr2_out};

  nmi_sync_bank #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(srst_n), .din(async_in), .dout(sync_out)
  );

  assign {perr_s_n, serr_s_n, chk_s_n, rfsh_s, ctr2_s} = sync_out;

  nmi_status_core u_core (
    .clk(clk), .rst_n(srst_n),
    .par_evt(~perr_s_n | ~serr_s_n), .chk_lvl(~chk_s_n), .rfsh_lvl(rfsh_s),
    .dis_par(ctrl_q.dis_par), .dis_chk(ctrl_q.dis_chk),
    .par_st(par_st), .chk_st(chk_st), .rfsh_tgl(rfsh_tgl)
  );

  nmi_host_regs #(.CTRL_ADDR(CTRL_ADDR), .MASK_ADDR(MASK_ADDR)) u_regs (
    .clk(clk), .rst_n(srst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .par_st(par_st), .chk_st(chk_st), .rfsh_tgl(rfsh_tgl), .ctr2_s(ctr2_s),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .idx_q(rtc_idx), .io_rdata(io_rdata)
  );

  assign spk_data  = ctrl_q.spk;
  assign ctr2_gate = ctrl_q.gate;
  assign nmi       = (par_st | chk_st) & ~mask_q;
endmodule

// File: rtl/nmi_legacy_chk.sv
module nmi_legacy_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       par_st,
  input logic       chk_st,
  input logic       dis_par,
  input logic       dis_chk,
  input logic       mask_q,
  input logic       rfsh_s,
  input logic       rfsh_tgl,
  input logic       nmi,
  input logic       io_wr,
  input logic [7:0] io_addr,
  input logic [7:0] io_wdata
);
  a_r2_dis_par_holds: assert property (@(posedge clk) disable iff (!srst_n)
    dis_par |=> !par_st);
  a_r4_dis_chk_holds: assert property (@(posedge clk) disable iff (!srst_n)
    dis_chk |=> !chk_st);
  a_r1_par_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    (par_st && !dis_par) |=> par_st);
  a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!srst_n)
    mask_q |-> !nmi);
  a_r5_nmi_raised: assert property (@(posedge clk) disable iff (!srst_n)
    ((par_st || chk_st) && !mask_q) |-> nmi);
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!srst_n)
    (io_wr && io_addr == 8'h70) |=> (mask_q == $past(io_wdata[7])));
  a_r8_refresh_flip: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(rfsh_s) |=> (rfsh_tgl != $past(rfsh_tgl)));
endmodule

bind nmi_legacy_unit nmi_legacy_chk u_chk (
  .clk(clk), .srst_n(srst_n), .par_st(par_st), .chk_st(chk_st),
  .dis_par(ctrl_q.dis_par), .dis_chk(ctrl_q.dis_chk), .mask_q(mask_q),
  .rfsh_s(rfsh_s), .rfsh_tgl(rfsh_tgl), .nmi(nmi),
  .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata)
);

// File: tb/sim_nmi_legacy_unit.sv
module sim_nmi_legacy_unit;
  logic       clk, rst_n, io_wr, perr_n, serr_n, iochk_n, rfsh_req, ctr2_out;
  logic [7:0] io_addr, io_wdata, io_rdata;
  logic       spk_data, ctr2_gate, nmi;
  logic [5:0] rtc_idx;
  int n_cmp, n_bad;
  logic done;

  nmi_legacy_unit u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .perr_n(perr_n), .serr_n(serr_n), .iochk_n(iochk_n),
    .rfsh_req(rfsh_req), .ctr2_out(ctr2_out), .spk_data(spk_data),
    .ctr2_gate(ctr2_gate), .rtc_idx(rtc_idx), .nmi(nmi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: ctrl[3:0] mask perr_n serr_n chk_n | exp_b7 exp_b6 exp_nmi
  localparam logic [10:0] VEC [8] = '{
    11'b0000_0_011_101, 11'b0000_0_101_101, 11'b0000_0_110_011,
    11'b0100_0_001_000, 11'b1000_0_110_000, 11'b0000_1_010_110,
    11'b0011_0_111_000, 11'b1101_0_000_000 };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a;
    #1 d = io_rdata;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [7:0] rd;
    logic [10:0] v;
    done = 1'b0; n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; io_wr = 1'b0; io_addr = 8'h00; io_wdata = 8'h00;
    perr_n = 1'b1; serr_n = 1'b1; iochk_n = 1'b1; rfsh_req = 1'b0; ctr2_out = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R10 reset state
    io_read(8'h61, rd); check("R10 port61", rd, 8'h00);
    io_read(8'h70, rd); check("R10 port70", rd, 8'h80);
    check("R10 nmi", {7'd0, nmi}, 8'h00);
    check("R10 rtc_idx", {2'b0, rtc_idx}, 8'h00);

    // table walk: R1 R2 R3 R4 R5 R7
    for (int k = 0; k < 8; k++) begin
      v = VEC[k];
      io_write(8'h61, {4'h0, v[10:7] | 4'b0100});
      io_write(8'h61, {4'h0, v[10:7]});
      io_write(8'h70, {v[6], 7'h00});
      @(negedge clk);
      perr_n = v[5]; serr_n = v[4]; iochk_n = v[3];
      wait_cyc(6);
      io_read(8'h61, rd);
      check("R1/R3 status", {6'd0, rd[7:6]}, {6'd0, v[2:1]});
      check("R7 ctrl readback", {4'd0, rd[3:0]}, {4'd0, v[10:7]});
      check("R5 nmi", {7'd0, nmi}, {7'd0, v[0]});
      check("R7 pins", {6'd0, spk_data, ctr2_gate}, {6'd0, v[8:7]});
      perr_n = 1'b1; serr_n = 1'b1; iochk_n = 1'b1;
      wait_cyc(6);
      io_read(8'h61, rd);
      check("R1/R4 after release", {6'd0, rd[7:6]}, {6'd0, v[2], 1'b0});
      check("R5 nmi after release", {7'd0, nmi}, {7'd0, v[2] & ~v[6]});
    end

    // R2 pulse clear with mask open
    io_write(8'h61, 8'h04); io_write(8'h61, 8'h00); io_write(8'h70, 8'h00);
    @(negedge clk); serr_n = 1'b0; wait_cyc(2); serr_n = 1'b1; wait_cyc(6);
    check("R1 short serr latched", {7'd0, nmi}, 8'h01);
    io_write(8'h61, 8'h04); wait_cyc(2);
    io_read(8'h61, rd); check("R2 held clear", {7'd0, rd[7]}, 8'h00);
    check("R2 nmi dropped", {7'd0, nmi}, 8'h00);
    io_write(8'h61, 8'h00); wait_cyc(3);
    io_read(8'h61, rd); check("R2 stays clear after pulse", {7'd0, rd[7]}, 8'h00);

    // R12 latency: status visible by third edge
    @(negedge clk); perr_n = 1'b0;
    wait_cyc(3); #1;
    check("R12 latency", {7'd0, nmi}, 8'h01);
    perr_n = 1'b1;
    io_write(8'h61, 8'h04); io_write(8'h61, 8'h00);

    // R6 port 70h fields
    io_write(8'h70, 8'h45); wait_cyc(1);
    check("R6 idx", {2'b0, rtc_idx}, 8'h05);
    io_read(8'h70, rd); check("R6 readback", rd, 8'h45);
    io_write(8'h70, 8'hBF); wait_cyc(1);
    check("R6 idx full", {2'b0, rtc_idx}, 8'h3F);
    io_read(8'h70, rd); check("R6 mask set", rd, 8'hBF);

    // R11 other addresses
    io_write(8'h61, 8'h02);
    io_write(8'h62, 8'hFF); io_write(8'h71, 8'h00);
    io_read(8'h61, rd); check("R11 port61 kept", {4'd0, rd[3:0]}, 8'h02);
    io_read(8'h70, rd); check("R11 port70 kept", rd, 8'hBF);
    io_read(8'h62, rd); check("R11 other read", rd, 8'h00);

    // R9 counter output
    @(negedge clk); ctr2_out = 1'b1; wait_cyc(4);
    io_read(8'h61, rd); check("R9 ctr2 high", {7'd0, rd[5]}, 8'h01);
    ctr2_out = 1'b0; wait_cyc(4);
    io_read(8'h61, rd); check("R9 ctr2 low", {7'd0, rd[5]}, 8'h00);

    // R8 refresh toggle
    for (int p = 0; p < 2; p++) begin
      @(negedge clk); rfsh_req = 1'b1; wait_cyc(3); rfsh_req = 1'b0; wait_cyc(5);
      io_read(8'h61, rd);
      check("R8 toggle", {7'd0, rd[4]}, (p == 0) ? 8'h01 : 8'h00);
    end

    done = 1'b1;
    summary();
  end
endmodule